// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block replaces software bit-banging of a one-time-programmable fuse macro during reads. A requester presents a start offset and an entry count for one clock cycle. The sequencer then takes over the macro control word. It switches the macro from its idle state into read mode and visits each address in ascending order, pulsing the strobe line once per address with timed settle waits around it. It hands every captured entry to the requester and finally parks the macro back in its idle state.

A compile-time parameter picks one of two macro flavours:

- **Byte flavour:** a 32-entry byte array. Mode entry takes two steps, the address is placed before the strobe rises, and each wait lasts 2 µs.
- **Word flavour:** a 128-entry 32-bit array. Mode entry takes one step, the address moves together with the strobe, each wait lasts 1 µs, and the macro is powered down at the end.

Wait lengths are cycle counts derived from the clock frequency parameter.

Top module: `efuse_rd_seq`

## Requirements
- R1: After reset and while idle, `fuse_ctrl` holds the idle word, and `busy`, `rd_valid`, `done` and `req_err` are low. The idle word is 0x009 in the byte flavour (chip-select-bar bit 0, program-enable-bar bit 3). It is 0x021 in the word flavour (chip-select-bar bit 0, power-down bit 5).
- R2: A request is refused when the count is zero or when offset plus count exceeds the array size (32 for byte, 128 for word). A refused request gives a one-cycle `req_err` pulse one cycle after it is presented, does not raise `busy` and leaves `fuse_ctrl` unchanged.
- R3: In the byte flavour, an accepted request first drives `fuse_ctrl` = 0x001 for one cycle. It then drives 0x00C (load bit 2 and program-enable-bar bit 3) for one wait.
- R4: In the word flavour, an accepted request first drives `fuse_ctrl` = 0x28C for one wait. That word sets strobe-shift-select bit 9, read-sense-bar bit 7, program-enable-bar bit 3 and load bit 2.
- R5: In the byte flavour, each address goes through three phases, each lasting one wait:
  - the read-mode word with the address in bits 15:6 and the strobe (bit 1) low;
  - the same word with the strobe high;
  - the same word with the strobe low again.
- R6: In the word flavour, each address goes through two phases, each lasting one wait:
  - the address in bits 25:16 appears in the same cycle the strobe rises, on top of 0x28C, and the strobe stays high;
  - the strobe falls while the address is held.
- R7: One wait lasts CLK_MHZ × 2 cycles in the byte flavour and CLK_MHZ × 1 cycles in the word flavour (100 and 50 cycles at 50 MHz).
- R8: The data input is sampled in the last cycle of each strobe-high wait. It is presented on `rd_data` with a one-cycle `rd_valid` pulse in the following cycle. The byte flavour keeps only bits 7:0. Entries come out in ascending address order, starting at the requested offset, with exactly `count` entries.
- R9: After the last entry, `fuse_ctrl` returns to the idle word. `done` pulses for one cycle in the first cycle that word is driven. `busy` is high from the cycle after acceptance through the `done` cycle and low after it.
- R10: A request presented while `busy` is high is ignored. It does not change the running sequence and does not start another sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_offset | input | OFF_W | First array index to read |
| req_count | input | OFF_W | Number of entries to read |
| req_err | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | Sequence in progress |
| fuse_ctrl | output | 32 | Control word driven to the fuse macro |
| fuse_dout | input | 32 | Data output of the fuse macro |
| rd_data | output | DW | Captured entry (8 or 32 bits) |
| rd_valid | output | 1 | One-cycle qualifier for `rd_data` |
| done | output | 1 | One-cycle pulse when the idle word is restored |

## Verification
The hardest situation to bring about is a second request arriving in the middle of a running sequence. It must leave no trace, so the bench presents a valid request thirty cycles into a run. It then confirms that the whole recorded control-word history and the entry stream match the first request alone, and that no further activity follows `done`. The byte flavour with offset zero is also awkward, because the address phase of entry 0 produces the same control word as mode entry. The bench compares merged run lengths, so this case is checked by timing rather than by a visible change. Full-array runs and last-entry boundaries are driven in both flavours.

// File: rtl/efuse_seq_pkg.sv
package efuse_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_LOAD,
        ST_ADDR,
        ST_STRB,
        ST_LOW,
        ST_STBY
    } seq_st_e;

    localparam int BIT_CSB   = 0;
    localparam int BIT_STRB  = 1;
    localparam int BIT_LOAD  = 2;
    localparam int BIT_PGENB = 3;
    localparam int BIT_PD    = 5;
    localparam int BIT_RSB   = 7;
    localparam int BIT_SSEL  = 9;
    localparam int FA_W      = 10;

    function automatic int arr_size(bit wide);
        return wide ? 128 : 32;
    endfunction

    function automatic int data_w(bit wide);
        return wide ? 32 : 8;
    endfunction

    function automatic int wait_us(bit wide);
        return wide ? 1 : 2;
    endfunction

    function automatic logic [31:0] idle_word(bit wide);
        logic [31:0] w;
        w = '0;
        w[BIT_CSB] = 1'b1;
        if (wide) w[BIT_PD] = 1'b1;
        else      w[BIT_PGENB] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] read_word(bit wide);
        logic [31:0] w;
        w = '0;
        w[BIT_LOAD]  = 1'b1;
        w[BIT_PGENB] = 1'b1;
        if (wide) begin
            w[BIT_SSEL] = 1'b1;
            w[BIT_RSB]  = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/efuse_req_chk.sv
module efuse_req_chk #(
    parameter int SIZE  = 32,
    parameter int OFF_W = 6
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [OFF_W-1:0] count,
    output logic             ok
);
    logic [OFF_W:0] span;

    always_comb begin
        span = {1'b0, offset} + {1'b0, count};
        ok   = (count != '0) && (span <= (OFF_W+1)'(SIZE));
    end
endmodule

// File: rtl/efuse_wait_tmr.sv
module efuse_wait_tmr #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic elapsed
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    assign elapsed = (cnt_q == CW'(CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt_q <= '0;
        else if (!elapsed) cnt_q <= cnt_q + 1'b1;
    end

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        elapsed |=> (elapsed || cnt_q == '0));
endmodule

// File: rtl/efuse_ctrl_enc.sv
module efuse_ctrl_enc
    import efuse_seq_pkg::*;
#(
    parameter bit WIDE  = 1'b0,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_st_e          st,
    input  logic [OFF_W-1:0] addr,
    output logic [31:0]      ctrl
);
    logic [FA_W-1:0] fa;
    logic [31:0]     field;

    assign fa = FA_W'(addr);

    generate
        if (WIDE) begin : g_word
            assign field = {6'b0, fa, 16'b0};
        end else begin : g_byte
            assign field = {16'b0, fa, 6'b0};
            // R5: address settles before strobe rises
            a_r5_addr_before_strobe: assert property (@(posedge clk) disable iff (rst)
                $rose(ctrl[BIT_STRB]) |-> $stable(ctrl[15:6]));
        end
    endgenerate

    always_comb begin
        ctrl = idle_word(WIDE);
        case (st)
            ST_SEL:          ctrl = 32'h1 << BIT_CSB;
            ST_LOAD:         ctrl = read_word(WIDE);
            ST_ADDR, ST_LOW: ctrl = read_word(WIDE) | field;
            ST_STRB:         ctrl = read_word(WIDE) | field | (32'h1 << BIT_STRB);
            default:         ctrl = idle_word(WIDE);
        endcase
    end

    a_r6_addr_held_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl[BIT_STRB]) |-> $stable(ctrl[25:6]));
endmodule

// File: rtl/efuse_rd_seq.sv
module efuse_rd_seq
    import efuse_seq_pkg::*;
#(
    parameter bit  WIDE    = 1'b0,
    parameter int  CLK_MHZ = 50,
    localparam int SIZE    = arr_size(WIDE),
    localparam int OFF_W   = $clog2(SIZE) + 1,
    localparam int DW      = data_w(WIDE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [OFF_W-1:0] req_count,
    output logic             req_err,
    output logic             busy,
    output logic [31:0]      fuse_ctrl,
    input  logic [31:0]      fuse_dout,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             done
);
    localparam int WAIT_CYC = CLK_MHZ * wait_us(WIDE);

    seq_st_e          st_q, st_d;
    logic [OFF_W-1:0] addr_q, left_q;
    logic             req_ok, t_clr, t_done, accept, last;

    efuse_req_chk #(.SIZE(SIZE), .OFF_W(OFF_W)) u_chk (
        .offset(req_offset), .count(req_count), .ok(req_ok));

    efuse_wait_tmr #(.CYC(WAIT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .clr(t_clr), .elapsed(t_done));

    efuse_ctrl_enc #(.WIDE(WIDE), .OFF_W(OFF_W)) u_enc (
        .clk(clk), .rst(rst), .st(st_q), .addr(addr_q), .ctrl(fuse_ctrl));

    generate
        if (DW < 32) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^fuse_dout[31:DW];
        end
    endgenerate

    assign accept = (st_q == ST_IDLE) && req_valid && req_ok;
    assign last   = (left_q == OFF_W'(1));
    assign busy   = (st_q != ST_IDLE);
    assign done   = (st_q == ST_STBY);
    assign t_clr  = (st_d != st_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (accept) st_d = WIDE ? ST_LOAD : ST_SEL;
            ST_SEL:  st_d = ST_LOAD;
            ST_LOAD: if (t_done) st_d = WIDE ? ST_STRB : ST_ADDR;
            ST_ADDR: if (t_done) st_d = ST_STRB;
            ST_STRB: if (t_done) st_d = ST_LOW;
            ST_LOW:  if (t_done) st_d = last ? ST_STBY : (WIDE ? ST_STRB : ST_ADDR);
            ST_STBY: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            addr_q   <= '0;
            left_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            req_err  <= 1'b0;
        end else begin
            st_q     <= st_d;
            rd_valid <= (st_q == ST_STRB) && t_done;
            if ((st_q == ST_STRB) && t_done) rd_data <= fuse_dout[DW-1:0];
            req_err  <= (st_q == ST_IDLE) && req_valid && !req_ok;
            if (accept) begin
                addr_q <= req_offset;
                left_q <= req_count;
            end else if ((st_q == ST_LOW) && t_done && !last) begin
                addr_q <= addr_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    a_r8_valid_inside_run: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);
    a_r2_err_keeps_idle: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !busy);
    a_r5_strobe_in_read_mode: assert property (@(posedge clk) disable iff (rst)
        fuse_ctrl[BIT_STRB] |-> (fuse_ctrl[BIT_PGENB] && !fuse_ctrl[BIT_CSB]));
    a_r1_idle_word: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fuse_ctrl == idle_word(WIDE)));
endmodule

// File: tb/tb_efuse_rd_seq.sv
module tb_efuse_rd_seq;
    localparam int WB = 100;
    localparam int WW = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    logic        b_req = 1'b0, b_err, b_busy, b_valid, b_done;
    logic [5:0]  b_off = '0, b_cnt = '0;
    logic [31:0] b_ctrl, b_dout;
    logic [7:0]  b_data;
    logic        w_req = 1'b0, w_err, w_busy, w_valid, w_done;
    logic [7:0]  w_off = '0, w_cnt = '0;
    logic [31:0] w_ctrl, w_dout, w_data;

    function automatic logic [7:0] fb(int a);
        return 8'(a * 13 + 7);
    endfunction
    function automatic logic [31:0] fw(int a);
        return 32'h6C0F_0000 ^ (32'(a) * 32'h0001_9E37);
    endfunction

    assign b_dout = {24'hA5C35A, fb(int'(b_ctrl[15:6]))};
    assign w_dout = fw(int'(w_ctrl[25:16]));

    efuse_rd_seq #(.WIDE(1'b0), .CLK_MHZ(50)) dut (
        .clk(clk), .rst(rst), .req_valid(b_req), .req_offset(b_off), .req_count(b_cnt),
        .req_err(b_err), .busy(b_busy), .fuse_ctrl(b_ctrl), .fuse_dout(b_dout),
        .rd_data(b_data), .rd_valid(b_valid), .done(b_done));

    efuse_rd_seq #(.WIDE(1'b1), .CLK_MHZ(50)) dut_w (
        .clk(clk), .rst(rst), .req_valid(w_req), .req_offset(w_off), .req_count(w_cnt),
        .req_err(w_err), .busy(w_busy), .fuse_ctrl(w_ctrl), .fuse_dout(w_dout),
        .rd_data(w_data), .rd_valid(w_valid), .done(w_done));

    int checks = 0;
    int errors = 0;

    logic [31:0] lv_val [2][512];
    int          lv_t   [2][512];
    int          lv_n   [2];
    logic [31:0] last_c [2];
    logic [31:0] dv     [2][256];
    int          dn     [2];
    int          dc     [2];
    int          errc   [2];
    int          bz_bad [2];
    bit          bz_seen[2];
    bit          pdone  [2];

    task automatic mon(int i, logic [31:0] c, logic [31:0] d, logic v, logic dn_i,
                       logic er, logic bz);
        if (c != last_c[i]) begin
            if (lv_n[i] < 512) begin
                lv_val[i][lv_n[i]] = c;
                lv_t[i][lv_n[i]]   = cyc;
            end
            lv_n[i]++;
            last_c[i] = c;
        end
        if (v) begin
            if (dn[i] < 256) dv[i][dn[i]] = d;
            dn[i]++;
        end
        if (dn_i) begin
            dc[i]++;
            if (!bz) bz_bad[i]++;
        end
        if (pdone[i] && bz) bz_bad[i]++;
        pdone[i] = dn_i;
        if (er) errc[i]++;
        if (bz) bz_seen[i] = 1'b1;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            mon(0, b_ctrl, 32'(b_data), b_valid, b_done, b_err, b_busy);
            mon(1, w_ctrl, w_data, w_valid, w_done, w_err, w_busy);
        end
    end

    task automatic check(string tag, bit ok, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear(int i);
        lv_n[i] = 0; dn[i] = 0; dc[i] = 0; errc[i] = 0;
        bz_bad[i] = 0; bz_seen[i] = 1'b0; pdone[i] = 1'b0;
        last_c[i] = (i == 0) ? b_ctrl : w_ctrl;
    endtask

    logic [31:0] ex_val [512];
    int          ex_dur [512];
    int          ex_n;

    task automatic ex_push(logic [31:0] v, int d);
        if (ex_n > 0 && ex_val[ex_n-1] == v) ex_dur[ex_n-1] += d;
        else begin
            ex_val[ex_n] = v;
            ex_dur[ex_n] = d;
            ex_n++;
        end
    endtask

    // Expected control-word history (R3..R7)
    task automatic build(int i, int o, int n);
        ex_n = 0;
        if (i == 0) begin
            ex_push(32'h001, 1);
            ex_push(32'h00C, WB);
            for (int k = 0; k < n; k++) begin
                ex_push(32'h00C | (32'(o + k) << 6), WB);
                ex_push(32'h00E | (32'(o + k) << 6), WB);
                ex_push(32'h00C | (32'(o + k) << 6), WB);
            end
            ex_push(32'h009, 0);
        end else begin
            ex_push(32'h28C, WW);
            for (int k = 0; k < n; k++) begin
                ex_push(32'h28E | (32'(o + k) << 16), WW);
                ex_push(32'h28C | (32'(o + k) << 16), WW);
            end
            ex_push(32'h021, 0);
        end
    endtask

    task automatic drive(int i, int o, int n, logic v);
        if (i == 0) begin
            b_req = v; b_off = 6'(o); b_cnt = 6'(n);
        end else begin
            w_req = v; w_off = 8'(o); w_cnt = 8'(n);
        end
    endtask

    task automatic run(int i, int o, int n, bit intrude);
        int t;
        bit ok;
        int bad;
        clear(i);
        @(negedge clk) drive(i, o, n, 1'b1);
        @(negedge clk) drive(i, 0, 0, 1'b0);
        if (intrude) begin
            repeat (30) @(negedge clk);
            drive(i, 0, 1, 1'b1);
            @(negedge clk) drive(i, 0, 0, 1'b0);
        end
        t = 0;
        while (dc[i] == 0 && t < 40000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);

        build(i, o, n);
        ok = (lv_n[i] == ex_n);
        bad = -1;
        for (int j = 0; j < ex_n && j < lv_n[i]; j++) begin
            if (bad < 0 && lv_val[i][j] != ex_val[j]) bad = j;
            if (bad < 0 && j < ex_n - 1 && (lv_t[i][j+1] - lv_t[i][j]) != ex_dur[j]) bad = j;
        end
        if (bad >= 0) ok = 1'b0;
        if (i == 0)
            check("R3 R5 R7 byte control sequence", ok,
                  (bad >= 0) ? lv_val[i][bad] : 32'(lv_n[i]),
                  (bad >= 0) ? ex_val[bad] : 32'(ex_n));
        else
            check("R4 R6 R7 word control sequence", ok,
                  (bad >= 0) ? lv_val[i][bad] : 32'(lv_n[i]),
                  (bad >= 0) ? ex_val[bad] : 32'(ex_n));

        ok = (dn[i] == n);
        bad = -1;
        for (int k = 0; k < n && k < dn[i]; k++) begin
            logic [31:0] e;
            e = (i == 0) ? 32'(fb(o + k)) : fw(o + k);
            if (bad < 0 && dv[i][k] != e) bad = k;
        end
        if (bad >= 0) ok = 1'b0;
        check("R8 captured entries", ok,
              (bad >= 0) ? dv[i][bad] : 32'(dn[i]),
              (bad >= 0) ? ((i == 0) ? 32'(fb(o + bad)) : fw(o + bad)) : 32'(n));

        check("R9 single done with busy span", dc[i] == 1 && bz_bad[i] == 0,
              32'(dc[i] * 16 + bz_bad[i]), 32'h10);
        if (intrude)
            check("R10 request during run ignored", dc[i] == 1 && dn[i] == n,
                  32'(dn[i]), 32'(n));
        check("R2 no error on valid request", errc[i] == 0, 32'(errc[i]), 0);
    endtask

    task automatic refuse(int i, int o, int n);
        clear(i);
        @(negedge clk) drive(i, o, n, 1'b1);
        @(negedge clk) drive(i, 0, 0, 1'b0);
        repeat (6) @(negedge clk);
        check("R2 refused request pulse", errc[i] == 1, 32'(errc[i]), 1);
        check("R2 refused request leaves macro idle", !bz_seen[i] && lv_n[i] == 0,
              32'(lv_n[i]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 byte idle word", b_ctrl == 32'h009, b_ctrl, 32'h009);
        check("R1 word idle word", w_ctrl == 32'h021, w_ctrl, 32'h021);
        check("R1 outputs quiet", !b_busy && !b_valid && !b_done && !b_err &&
              !w_busy && !w_valid && !w_done && !w_err, 0, 0);

        run(0, 3, 4, 1'b0);
        run(0, 0, 1, 1'b0);
        run(0, 30, 2, 1'b0);
        run(0, 10, 3, 1'b1);
        run(0, 0, 32, 1'b0);
        refuse(0, 31, 2);
        refuse(0, 5, 0);
        refuse(0, 40, 1);

        run(1, 5, 3, 1'b0);
        run(1, 126, 2, 1'b0);
        run(1, 20, 2, 1'b1);
        run(1, 0, 128, 1'b0);
        refuse(1, 127, 2);
        refuse(1, 0, 0);
        refuse(1, 200, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule